// File: doc/BRIEF.md
# Stretchable Multiplexed External Memory Bus Sequencer

This block runs external memory cycles for a processor core over two byte-wide ports. One port is multiplexed: it carries the low address byte first and then the data. The other port holds the high address byte. The block drives the address latch enable, the program store enable strobe and separate read and write strobes. On the core side there is a small handshake: a request with an address, write data and a transfer kind; a ready signal that holds off new requests while a cycle runs; and a one-clock done pulse that comes with the read data.

Every external cycle is built from machine cycles of four system clocks. Program fetches always take one machine cycle. Data reads and data writes take one machine cycle plus a number of stretch machine cycles. That number comes from a 3-bit stretch code that software can rewrite at any time. The code is mapped to a stretch count that is not linear: codes 0 to 3 give 0 to 3 stretch cycles, and codes 4 to 7 give 7 to 10. The code is captured when a data cycle is accepted, so a rewrite during a cycle only affects later cycles. All state advances only on clocks where the clock enable is high.

Top module: `xmem_bus_seq`

## Requirements
- R1: After reset the bus is idle. Request ready is high and done is low. ALE is low and the three strobes are high. The multiplexed port is not driven (ad_oe low), the high address port is 0, and the stretch code reads 000.
- R2: A program fetch (req_kind 2'b00) lasts exactly 4 clocks whatever the stretch code is. psen_n is low in its 2nd and 3rd clocks, and rd_n and wr_n stay high.
- R3: A data read (2'b01, 2'b11 treated as read) or data write (2'b10) lasts 4·(1+S) clocks, where S is 0,1,2,3,7,8,9,10 for stretch codes 000 to 111.
- R4: In the first clock of every cycle, ALE is high and the multiplexed port drives the low address byte. ALE is low in every other clock of the cycle. The high address port carries the upper address byte for the whole cycle.
- R5: On a write, the multiplexed port stays driven. It carries the write data from the 2nd clock to the end of the cycle. wr_n is low from the 2nd clock through the next-to-last clock.
- R6: On a read or fetch, the port is released from the 2nd clock on. rd_n (or psen_n) is low from the 2nd clock through the next-to-last clock. The value of ad_in during the next-to-last clock appears on rdata, and done is high in the last clock.
- R7: The stretch code is captured when a data request is accepted. Writing a new code during a cycle does not change that cycle's length, but it sets the length of the next data cycle.
- R8: Request ready is low from the first clock of a cycle up to, but not including, its last clock. A request that is valid while ready is low is ignored. A request that is valid in the last clock starts its first clock on the very next clock.
- R9: While clk_en is low, no output and no internal state changes, and neither requests nor stretch-code writes take effect.
- R10: A stretch-code write (cfg_we with clk_en) shows up on cfg_code on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable for all state |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Data read in the completed cycle |
| cfg_we | input | 1 | Stretch-code write strobe |
| cfg_wdata | input | 3 | New stretch code |
| cfg_code | output | 3 | Current stretch code |
| ad_out | output | 8 | Multiplexed address/data, output value |
| ad_oe | output | 1 | Output enable for the multiplexed port |
| ad_in | input | 8 | Multiplexed port, input value |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit data port and 4 clocks per machine cycle. With these values a data cycle can be as short as 4 clocks or as long as 44 clocks. The bench therefore reaches both ends of the stretch map, including the jump from code 011 to code 100. It also reaches a code rewrite in the middle of a cycle, requests that arrive during a cycle or back to back, and clock-enable stalls.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  localparam int STRETCH_CODE_W = 3;
  localparam int MAX_STRETCH    = 10;
  localparam int STRETCH_CNT_W  = 4;

  typedef enum logic [1:0] {
    XK_FETCH = 2'b00,
    XK_READ  = 2'b01,
    XK_WRITE = 2'b10,
    XK_RSVD  = 2'b11
  } xk_e;

  // Codes 0..3 map to themselves, codes 4..7 map to 7..10.
  function automatic logic [STRETCH_CNT_W-1:0] stretch_count(
    input logic [STRETCH_CODE_W-1:0] code
  );
    logic [STRETCH_CNT_W-1:0] base;
    base = {1'b0, code};
    return code[STRETCH_CODE_W-1] ? base + STRETCH_CNT_W'(3) : base;
  endfunction

endpackage

// File: rtl/xmb_rst_sync.sv
module xmb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/xmb_stretch_reg.sv
module xmb_stretch_reg
  import xmb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en,
  input  logic                      cfg_we,
  input  logic [STRETCH_CODE_W-1:0] cfg_wdata,
  output logic [STRETCH_CODE_W-1:0] code,
  output logic [STRETCH_CNT_W-1:0]  stretch
);
  logic [STRETCH_CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (cfg_we) code_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (clk_en) code_q <= code_d;
  end

  assign code    = code_q;
  assign stretch = stretch_count(code_q);
endmodule

// File: rtl/xmb_cycle_ctrl.sv
module xmb_cycle_ctrl
  import xmb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CLKS_PER_MC = 4,
  localparam int MAX_CLKS   = CLKS_PER_MC * (MAX_STRETCH + 1),
  localparam int CNT_W      = $clog2(MAX_CLKS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [STRETCH_CNT_W-1:0] stretch,
  output logic                     req_ready,
  output logic                     busy,
  output logic [CNT_W-1:0]         tcnt,
  output logic [CNT_W-1:0]         tlast,
  output xk_e                      kind,
  output logic [ADDR_W-1:0]        addr,
  output logic [DATA_W-1:0]        wdata
);
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [CNT_W-1:0]  tlast_q, tlast_d;
  xk_e               kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  logic              at_end, accept;
  xk_e               kind_in;
  logic [CNT_W-1:0]  mc_clks, fetch_last, data_last;

  assign mc_clks    = CNT_W'(CLKS_PER_MC);
  assign fetch_last = mc_clks - CNT_W'(1);
  assign data_last  = CNT_W'(mc_clks * (CNT_W'(stretch) + CNT_W'(1))) - CNT_W'(1);

  assign at_end    = busy_q && (tcnt_q == tlast_q);
  assign req_ready = !busy_q || at_end;
  assign accept    = req_valid && req_ready;

  always_comb begin
    case (req_kind)
      2'b00:   kind_in = XK_FETCH;
      2'b10:   kind_in = XK_WRITE;
      default: kind_in = XK_READ;
    endcase
  end

  always_comb begin
    busy_d  = busy_q;
    tcnt_d  = tcnt_q;
    tlast_d = tlast_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (accept) begin
      busy_d  = 1'b1;
      tcnt_d  = '0;
      kind_d  = kind_in;
      addr_d  = req_addr;
      wdata_d = req_wdata;
      tlast_d = (kind_in == XK_FETCH) ? fetch_last : data_last;
    end else if (at_end) begin
      busy_d = 1'b0;
      tcnt_d = '0;
    end else if (busy_q) begin
      tcnt_d = tcnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tcnt_q  <= '0;
      tlast_q <= '0;
      kind_q  <= XK_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (clk_en) begin
      busy_q  <= busy_d;
      tcnt_q  <= tcnt_d;
      tlast_q <= tlast_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign busy  = busy_q;
  assign tcnt  = tcnt_q;
  assign tlast = tlast_q;
  assign kind  = kind_q;
  assign addr  = addr_q;
  assign wdata = wdata_q;
endmodule

// File: rtl/xmb_pad_mux.sv
module xmb_pad_mux
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              busy,
  input  logic [CNT_W-1:0]  tcnt,
  input  logic [CNT_W-1:0]  tlast,
  input  xk_e               kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic              first, mid, sample_now, is_write;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  assign first      = busy && (tcnt == '0);
  assign mid        = busy && (tcnt != '0) && (tcnt != tlast);
  assign is_write   = (kind == XK_WRITE);
  assign sample_now = busy && !is_write && (tcnt == CNT_W'(tlast - CNT_W'(1)));

  assign ale    = first;
  assign ad_oe  = first || (busy && is_write);
  assign ad_out = first ? addr[DATA_W-1:0] : wdata;
  assign a_hi   = addr[ADDR_W-1:DATA_W];
  assign psen_n = !(mid && (kind == XK_FETCH));
  assign rd_n   = !(mid && (kind == XK_READ));
  assign wr_n   = !(mid && is_write);
  assign done   = busy && (tcnt == tlast);

  always_comb begin
    rdata_d = rdata_q;
    if (sample_now) rdata_d = ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (clk_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
  import xmb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CLKS_PER_MC = 4,
  localparam int HI_W       = ADDR_W - DATA_W,
  localparam int CNT_W      = $clog2(CLKS_PER_MC * (MAX_STRETCH + 1))
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_kind,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      done,
  output logic [DATA_W-1:0]         rdata,
  input  logic                      cfg_we,
  input  logic [STRETCH_CODE_W-1:0] cfg_wdata,
  output logic [STRETCH_CODE_W-1:0] cfg_code,
  output logic [DATA_W-1:0]         ad_out,
  output logic                      ad_oe,
  input  logic [DATA_W-1:0]         ad_in,
  output logic [HI_W-1:0]           a_hi,
  output logic                      ale,
  output logic                      psen_n,
  output logic                      rd_n,
  output logic                      wr_n
);
  logic                     rst_sync_n;
  logic [STRETCH_CNT_W-1:0] stretch;
  logic                     busy;
  logic [CNT_W-1:0]         tcnt, tlast;
  xk_e                      kind;
  logic [ADDR_W-1:0]        addr;
  logic [DATA_W-1:0]        wdata;

  xmb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xmb_stretch_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clk_en    (clk_en),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .code      (cfg_code),
    .stretch   (stretch)
  );

  xmb_cycle_ctrl #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CLKS_PER_MC (CLKS_PER_MC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clk_en    (clk_en),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .stretch   (stretch),
    .req_ready (req_ready),
    .busy      (busy),
    .tcnt      (tcnt),
    .tlast     (tlast),
    .kind      (kind),
    .addr      (addr),
    .wdata     (wdata)
  );

  xmb_pad_mux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_pads (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clk_en (clk_en),
    .busy   (busy),
    .tcnt   (tcnt),
    .tlast  (tlast),
    .kind   (kind),
    .addr   (addr),
    .wdata  (wdata),
    .ad_in  (ad_in),
    .ale    (ale),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .a_hi   (a_hi),
    .psen_n (psen_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .done   (done),
    .rdata  (rdata)
  );
endmodule

// File: rtl/xmb_checker.sv
module xmb_checker #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe,
  input logic [DATA_W-1:0] ad_out,
  input logic [HI_W-1:0]   a_hi,
  input logic              req_ready,
  input logic              done,
  input logic [DATA_W-1:0] rdata
);
  a_r4_ale_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && clk_en) |=> !ale);

  a_r4_ale_drives_port: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && psen_n && rd_n && wr_n));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  a_r6_read_port_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe);

  a_r5_write_port_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  a_r8_busy_while_strobing: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n || !psen_n || ale) |-> !req_ready);

  a_r8_done_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable({ale, psen_n, rd_n, wr_n, ad_oe, ad_out, a_hi, req_ready, done, rdata}));
endmodule

bind xmem_bus_seq xmb_checker #(.DATA_W(DATA_W), .HI_W(HI_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .clk_en    (clk_en),
  .ale       (ale),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .ad_out    (ad_out),
  .a_hi      (a_hi),
  .req_ready (req_ready),
  .done      (done),
  .rdata     (rdata)
);

// File: tb/xmem_bus_seq_tb.sv
module xmem_bus_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, clk_en;
  logic       req_valid, req_ready;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, rdata, ad_out, ad_in, a_hi;
  logic       done, cfg_we, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [2:0] cfg_wdata, cfg_code;

  int n_vec = 0;
  int n_bad = 0;
  int code_m = 0;
  logic [7:0] last_hi = 8'h00;

  xmem_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_code(cfg_code),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", WATCHDOG, WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  function automatic int stretch_of(input int code);
    return (code < 4) ? code : code + 3;
  endfunction

  function automatic int len_of(input logic [1:0] kind, input int code);
    return (kind == 2'b00) ? 4 : 4 * (1 + stretch_of(code));
  endfunction

  // {ale, ad_oe, ad_out(masked), psen_n, rd_n, wr_n, a_hi, ready, done}
  function automatic logic [22:0] exp_vec(input logic [1:0] kind, input int t, input int len,
                                          input logic [15:0] addr, input logic [7:0] wd);
    logic oe, mid;
    logic [7:0] d;
    mid = (t >= 1) && (t <= len - 2);
    oe  = (t == 0) || (kind == 2'b10);
    d   = !oe ? 8'h00 : (t == 0) ? addr[7:0] : wd;
    return {t == 0, oe, d, !(mid && kind == 2'b00), !(mid && kind[0]),
            !(mid && kind == 2'b10), addr[15:8], t == len - 1, t == len - 1};
  endfunction

  function automatic logic [22:0] idle_vec(input logic [7:0] hi);
    return {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, hi, 1'b1, 1'b0};
  endfunction

  function automatic logic [22:0] act_vec();
    return {ale, ad_oe, ad_oe ? ad_out : 8'h00, psen_n, rd_n, wr_n, a_hi, req_ready, done};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    check(act_vec() == idle_vec(last_hi), tag, 32'(act_vec()), 32'(idle_vec(last_hi)));
  endtask

  task automatic set_code(input int c);
    cfg_we = 1'b1; cfg_wdata = 3'(c);
    @(negedge clk);
    cfg_we = 1'b0;
    code_m = c;
    check(cfg_code == 3'(c), "R10 code readback", 32'(cfg_code), 32'(c));
    check_idle("R8 idle during code write");
  endtask

  // Called at a negedge; returns at the negedge of the cycle's last clock.
  task automatic run_txn(input logic [1:0] kind, input logic [15:0] addr, input logic [7:0] wd,
                         input logic [7:0] rv, input bit spam, input int freeze_t, input int newcode);
    int len;
    string tag;
    len = len_of(kind, code_m);
    tag = (kind == 2'b00) ? "R2/R4 fetch" : (kind == 2'b10) ? "R3/R5 write" : "R3/R6 read";
    req_kind = kind; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    check(req_ready == 1'b1, "R8 ready before accept", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = spam;
    if (spam) begin req_kind = 2'b10; req_addr = ~addr; req_wdata = ~wd; end
    for (int t = 0; t < len; t++) begin
      ad_in = (t == len - 2) ? rv : ~rv;
      check(act_vec() == exp_vec(kind, t, len, addr, wd), tag,
            32'(act_vec()), 32'(exp_vec(kind, t, len, addr, wd)));
      if (newcode >= 0 && t == 1) begin cfg_we = 1'b1; cfg_wdata = 3'(newcode); end
      if (newcode >= 0 && t == 2) begin
        cfg_we = 1'b0; code_m = newcode;
        check(cfg_code == 3'(newcode), "R7 code updated mid-cycle", 32'(cfg_code), 32'(newcode));
      end
      if (freeze_t == t) begin
        clk_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check(act_vec() == exp_vec(kind, t, len, addr, wd), "R9 stall holds",
                32'(act_vec()), 32'(exp_vec(kind, t, len, addr, wd)));
        end
        clk_en = 1'b1;
      end
      if (spam && t == len - 2) req_valid = 1'b0;
      if (t == len - 1) begin
        if (kind != 2'b10)
          check(rdata == rv, "R6 read data", 32'(rdata), 32'(rv));
      end else begin
        @(negedge clk);
      end
    end
    last_hi = addr[15:8];
  endtask

  task automatic go_idle(input int n);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_idle("R8 idle");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; clk_en = 1'b1; req_valid = 1'b0; req_kind = 2'b00;
    req_addr = '0; req_wdata = '0; cfg_we = 1'b0; cfg_wdata = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 reset idle");
    check(cfg_code == 3'd0, "R1 reset code", 32'(cfg_code), 32'd0);

    // Directed corners
    run_txn(2'b00, 16'h12A5, 8'h00, 8'h3C, 1'b0, -1, -1); go_idle(2);
    run_txn(2'b01, 16'hBEEF, 8'h00, 8'hC3, 1'b0, -1, -1); go_idle(1);
    run_txn(2'b10, 16'h0F0F, 8'h99, 8'h00, 1'b0, -1, -1); go_idle(1);
    set_code(3);
    run_txn(2'b01, 16'h7001, 8'h00, 8'h81, 1'b0, -1, -1); go_idle(1);   // R3 len 16
    set_code(4);
    run_txn(2'b10, 16'h8002, 8'h42, 8'h00, 1'b0, -1, -1); go_idle(1);   // R3 len 32
    set_code(7);
    run_txn(2'b11, 16'hFFFF, 8'h00, 8'h5A, 1'b0, -1, -1); go_idle(1);   // R3 len 44
    run_txn(2'b00, 16'h4321, 8'h00, 8'h18, 1'b0, -1, -1); go_idle(1);   // R2 no stretch
    run_txn(2'b01, 16'h2222, 8'h00, 8'h77, 1'b0, -1, 1);                // R7 old length kept
    run_txn(2'b01, 16'h3333, 8'h00, 8'h66, 1'b0, -1, -1); go_idle(1);   // R7 new length
    run_txn(2'b10, 16'hA0A0, 8'h11, 8'h00, 1'b1, -1, -1); go_idle(1);   // R8 held-off request
    run_txn(2'b01, 16'h5A5A, 8'h00, 8'hE7, 1'b0, 1, -1);                // R9 stall
    run_txn(2'b10, 16'h6B6B, 8'hD4, 8'h00, 1'b0, -1, -1);               // R8 back to back
    run_txn(2'b00, 16'h7C7C, 8'h00, 8'h2B, 1'b0, -1, -1); go_idle(1);
    // R9: code write ignored while clk_en low
    clk_en = 1'b0; cfg_we = 1'b1; cfg_wdata = 3'd6;
    @(negedge clk);
    cfg_we = 1'b0; clk_en = 1'b1;
    check(cfg_code == 3'(code_m), "R9 code write gated", 32'(cfg_code), 32'(code_m));

    // Constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) set_code(int'($urandom_range(0, 7)));
      run_txn(k, 16'($urandom), 8'($urandom), 8'($urandom),
              1'($urandom_range(0, 1)), -1, -1);
      if ($urandom_range(0, 1) == 1) go_idle(int'($urandom_range(1, 3)));
    end
    go_idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule